// File: doc/BRIEF.md
# Layer Tile Instruction Sequencer

This controller sits between a host-fed instruction queue and the buffers and compute array of a convolution accelerator. It takes one coarse instruction at a time from a first-word-fall-through FIFO and expands it into the enables that the buffers and processing elements need to handle one layer tile. It runs instructions strictly in order: the next word is taken from the FIFO only after the unit addressed by the current one has reported completion.

Three kinds of work exist. The first fills the input buffer with everything the next computation needs. The second walks a group of output tiles, starting each in turn and waiting for it to finish. The third drains the output buffer to one of two destinations. Partial sums go back into the processing elements so they can keep accumulating. Final results go to external memory through a DMA request. A fourth code does nothing. The DMA engine, the buffers and the arithmetic are outside the block; it sees only their request and completion signals.

Top module: `tile_seq_top`

## Requirements
- R1: While rst_n is low and after reset, fifo_pop, load_req, tile_start, dma_req and fb_valid are low and tile_idx is 0.
- R2: When the sequencer is idle and fifo_empty is high, every enable and fifo_pop stay low.
- R3: fifo_pop is high only in an idle cycle with fifo_empty low, and it never rises while any unit is busy with the previous instruction, so instructions run strictly in order.
- R4: Instruction bits [1:0] select the operation: 00 load, 01 compute, 10 save, 11 no-op. Bit 2 is the save destination: 0 sends results to the processing elements, 1 sends them to external memory. All other bits, and bit 2 on non-save codes, are ignored. A no-op returns to idle with no enable raised.
- R5: After a load is popped, load_req is high from the next cycle and stays high until a cycle in which load_done is sampled high. It is low in the cycle after that.
- R6: A compute instruction produces TILES (default 4) one-cycle tile_start pulses, with tile_idx 0,1,2,3 in ascending order. The first pulse comes in the cycle after the pop. Each later pulse comes in the cycle after tile_done is sampled during the wait for the previous tile. After the last tile_done the block returns to idle.
- R7: A save to external memory raises dma_req in the cycle after the pop and holds it until dma_ack is sampled high.
- R8: A save to the processing elements raises fb_valid in the cycle after the pop and holds it until fb_ready is sampled high, which makes one transfer.
- R9: load_done, tile_done, dma_ack and fb_ready are ignored outside the state that waits for them, including tile_done in the cycle of a tile_start pulse.
- R10: At most one of load_req, tile_start, dma_req and fb_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | Instruction FIFO has no word |
| fifo_rdata | input | INSTR_W | Head word of the instruction FIFO (fall-through) |
| fifo_pop | output | 1 | Consume the head word this cycle |
| load_req | output | 1 | Input buffer fill enable |
| load_done | input | 1 | Input buffer fill finished |
| tile_start | output | 1 | One-cycle start of one output tile |
| tile_idx | output | TILE_W | Index of the tile being computed |
| tile_done | input | 1 | Current tile finished |
| fb_valid | output | 1 | Output buffer feeds results back to the processing elements |
| fb_ready | input | 1 | Feedback transfer accepted |
| dma_req | output | 1 | Output buffer write to external memory requested |
| dma_ack | input | 1 | External memory write accepted |

## Verification
The stream mixes every opcode. Some words set the upper bits or set the destination bit on codes that are not saves, which separates true decoding of the low field from decoding of the whole word. Completion responses arrive after zero to three cycles, so a design that needs an extra wait cycle is caught, and so is one that ignores a response arriving in the first cycle. Stray completion signals are driven in every state that does not wait for them, including the tile_start cycle. This exposes a sequencer that reacts to the wrong acknowledge. Gaps with an empty FIFO between instructions check that the block idles quietly and picks up again cleanly.

// File: rtl/tile_seq_pkg.sv
package tile_seq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_CALC = 2'b01,
        OP_SAVE = 2'b10,
        OP_NOP  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TSTART,
        ST_TWAIT,
        ST_SAVE_PE,
        ST_SAVE_DDR
    } st_e;

    localparam int OPC_W    = 2;
    localparam int DEST_BIT = 2;

    typedef struct packed {
        st_e st;
    } seq_regs_t;

endpackage

// File: rtl/tile_seq_decode.sv
module tile_seq_decode
    import tile_seq_pkg::*;
#(
    parameter int INSTR_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output op_e                op,
    output logic               to_ddr
);

    always_comb begin
        op     = op_e'(instr[OPC_W-1:0]);
        to_ddr = instr[DEST_BIT];
    end

endmodule

// File: rtl/tile_seq_tile_ctr.sv
module tile_seq_tile_ctr #(
    parameter int TILES  = 4,
    parameter int TILE_W = (TILES > 1) ? $clog2(TILES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [TILE_W-1:0] idx,
    output logic              last
);

    localparam logic [TILE_W-1:0] LAST_IDX = TILE_W'(TILES - 1);

    logic [TILE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = (cnt_q == LAST_IDX);
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign idx = cnt_q;

    // R6: the index never leaves the tile range
    p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    // R6: a step on the last tile wraps to zero
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last) |=> (cnt_q == '0));

endmodule

// File: rtl/tile_seq_top.sv
module tile_seq_top
    import tile_seq_pkg::*;
#(
    parameter int INSTR_W = 8,
    parameter int TILES   = 4,
    parameter int TILE_W  = (TILES > 1) ? $clog2(TILES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_empty,
    input  logic [INSTR_W-1:0] fifo_rdata,
    output logic               fifo_pop,
    output logic               load_req,
    input  logic               load_done,
    output logic               tile_start,
    output logic [TILE_W-1:0]  tile_idx,
    input  logic               tile_done,
    output logic               fb_valid,
    input  logic               fb_ready,
    output logic               dma_req,
    input  logic               dma_ack
);

    seq_regs_t r_d, r_q;
    op_e       head_op;
    logic      head_ddr;
    logic      ctr_clear, ctr_step, ctr_last;

    tile_seq_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr  (fifo_rdata),
        .op     (head_op),
        .to_ddr (head_ddr)
    );

    tile_seq_tile_ctr #(.TILES(TILES), .TILE_W(TILE_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctr_clear),
        .step  (ctr_step),
        .idx   (tile_idx),
        .last  (ctr_last)
    );

    always_comb begin
        r_d       = r_q;
        fifo_pop  = 1'b0;
        ctr_clear = 1'b0;
        ctr_step  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    unique case (head_op)
                        OP_LOAD: r_d.st = ST_LOAD;
                        OP_CALC: begin
                            r_d.st    = ST_TSTART;
                            ctr_clear = 1'b1;
                        end
                        OP_SAVE: r_d.st = head_ddr ? ST_SAVE_DDR : ST_SAVE_PE;
                        OP_NOP:  r_d.st = ST_IDLE;
                        default: r_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_LOAD:     if (load_done) r_d.st = ST_IDLE;
            ST_TSTART:   r_d.st = ST_TWAIT;
            ST_TWAIT: begin
                if (tile_done) begin
                    ctr_step = 1'b1;
                    r_d.st   = ctr_last ? ST_IDLE : ST_TSTART;
                end
            end
            ST_SAVE_PE:  if (fb_ready) r_d.st = ST_IDLE;
            ST_SAVE_DDR: if (dma_ack)  r_d.st = ST_IDLE;
            default:     r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_req   = (r_q.st == ST_LOAD);
    assign tile_start = (r_q.st == ST_TSTART);
    assign fb_valid   = (r_q.st == ST_SAVE_PE);
    assign dma_req    = (r_q.st == ST_SAVE_DDR);

    // R10: enables are mutually exclusive
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_req, tile_start, fb_valid, dma_req}));

    // R3: no pop while a unit is still working on the previous instruction
    p_inorder_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req || tile_start || fb_valid || dma_req) |-> !fifo_pop);

    // R3: pop only with a word present
    p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R5: load request held until done
    p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_done) |=> load_req);

    // R6: start is a single-cycle pulse with a stable index
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tile_start |=> (!tile_start && $stable(tile_idx)));

    // R7: DMA request held until acknowledged, then dropped
    p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);
    p_dma_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    // R8: feedback transfer held until accepted
    p_fb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && !fb_ready) |=> fb_valid);

endmodule

// File: tb/tile_seq_top_test.sv
module tile_seq_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int INSTR_W    = 8;
    localparam int TILES      = 4;
    localparam int TILE_W     = 2;
    localparam int WATCHDOG   = 20000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fifo_empty = 1'b1;
    logic [INSTR_W-1:0] fifo_rdata = '0;
    logic               fifo_pop;
    logic               load_req, tile_start, fb_valid, dma_req;
    logic [TILE_W-1:0]  tile_idx;
    logic               load_done = 1'b0, tile_done = 1'b0;
    logic               fb_ready = 1'b0, dma_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_seq_top #(.INSTR_W(INSTR_W), .TILES(TILES), .TILE_W(TILE_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
        .load_req(load_req), .load_done(load_done),
        .tile_start(tile_start), .tile_idx(tile_idx), .tile_done(tile_done),
        .fb_valid(fb_valid), .fb_ready(fb_ready),
        .dma_req(dma_req), .dma_ack(dma_ack)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: 0 idle,1 load,2 tile start,3 tile wait,4 save PE,5 save DDR
    int mst = 0, mtile = 0, mwait = 0, entries = 0, pops = 0;
    logic [INSTR_W-1:0] q[$];

    initial begin
        int cyc;
        int lat;
        bit noise, stall, eok;
        q = '{8'hA0, 8'h01, 8'h02, 8'hF8, 8'h05, 8'h06, 8'h03, 8'h07, 8'h4E, 8'h0A};
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "fifo_pop", fifo_pop, 0);
            chk("R1", "enables", {load_req, tile_start, fb_valid, dma_req}, 0);
            chk("R1", "tile_idx", tile_idx, 0);
        end
        rst_n = 1'b1;
        cyc = 0;
        while (!(q.size() == 0 && mst == 0) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            lat   = entries % 4;
            noise = (cyc % 3 == 1);
            stall = (cyc % 11) < 3;
            fifo_empty = (q.size() == 0) || stall;
            fifo_rdata = (q.size() != 0) ? q[0] : 8'h00;
            load_done  = (mst == 1) ? (mwait >= lat) : noise;
            tile_done  = (mst == 3) ? (mwait >= lat) : noise;
            fb_ready   = (mst == 4) ? (mwait >= lat) : noise;
            dma_ack    = (mst == 5) ? (mwait >= lat) : noise;
            #1;
            if (mst == 0 && fifo_empty) begin
                chk("R2", "idle enables", {fifo_pop, load_req, tile_start, fb_valid, dma_req}, 0);
            end
            chk("R3", "fifo_pop", fifo_pop, (mst == 0 && !fifo_empty) ? 1 : 0);
            chk("R5", "load_req", load_req, (mst == 1) ? 1 : 0);
            chk("R6", "tile_start", tile_start, (mst == 2) ? 1 : 0);
            chk("R6", "tile_idx", tile_idx, mtile);
            chk("R7", "dma_req", dma_req, (mst == 5) ? 1 : 0);
            chk("R8", "fb_valid", fb_valid, (mst == 4) ? 1 : 0);
            chk("R10", "onehot", ($countones({load_req, tile_start, fb_valid, dma_req}) <= 1) ? 1 : 0, 1);
            // advance model to the next edge; R9 other completions ignored, R4 decode of bits [1:0] and bit 2
            begin
                int nst;
                nst = mst;
                case (mst)
                    0: if (!fifo_empty) begin
                        logic [INSTR_W-1:0] w;
                        w = q.pop_front();
                        pops++;
                        case (w[1:0])
                            2'b00: nst = 1;
                            2'b01: begin nst = 2; mtile = 0; end
                            2'b10: nst = w[2] ? 5 : 4;
                            default: nst = 0;
                        endcase
                    end
                    1: if (load_done) nst = 0;
                    2: nst = 3;
                    3: if (tile_done) begin
                        if (mtile == TILES - 1) begin mtile = 0; nst = 0; end
                        else begin mtile++; nst = 2; end
                    end
                    4: if (fb_ready) nst = 0;
                    5: if (dma_ack) nst = 0;
                    default: nst = 0;
                endcase
                if (nst != mst) begin mwait = 0; entries++; end
                else mwait++;
                mst = nst;
            end
        end
        // final idle with an empty queue
        @(negedge clk);
        fifo_empty = 1'b1;
        #1;
        chk("R2", "idle after drain", {fifo_pop, load_req, tile_start, fb_valid, dma_req}, 0);
        chk("R3", "all instructions popped", pops, 10);
        eok = (q.size() == 0);
        chk("R4", "queue drained", eok, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule